// File: doc/BRIEF.md
# Branch and Jump Target Resolver

This block takes a control-transfer operation that has already been decoded, together with its operands. It decides whether the transfer redirects the instruction stream. It covers the six conditional branch forms and the register-indirect jump. It produces the next program counter, the link value with its write enable, and an instruction-address-misaligned exception that carries the offending address. The block is purely combinational. It sits between operand read and the fetch redirection logic.

The check for a misaligned target depends on whether compressed (16-bit) instructions are enabled. With compressed instructions enabled, any even target is legal. With them disabled, targets must be 4-byte aligned. In the 32-bit mode all comparisons and addresses work on sign-extended 32-bit quantities.

Top module: `brj_resolver`

## Requirements
- R1: Operation codes are 0 none, 1 equal, 2 not-equal, 3 signed less-than, 4 signed greater-or-equal, 5 unsigned less-than, 6 unsigned greater-or-equal, 7 indirect jump. For code 0, taken, excValid and linkWe are 0 and targetPc equals pc plus instLen.
- R2: Codes 1 to 6 evaluate their condition on rs1Val and rs2Val, and the branch is taken when the condition holds, provided no misalignment is raised.
- R3: A taken branch puts pc plus immVal on targetPc.
- R4: A branch whose condition fails drives targetPc to pc plus instLen with taken and excValid both 0, even if its target would be misaligned.
- R5: With compressedEn at 0, a branch whose condition holds and whose target has either of bits 1:0 set raises excValid with excAddr equal to the target, keeps taken at 0 and leaves targetPc at pc plus instLen.
- R6: With compressedEn at 1, a branch whose condition holds and whose target has bit 1 set is taken with no exception.
- R7: An indirect jump targets rs1Val plus immVal with bit 0 cleared, and it is taken.
- R8: With compressedEn at 0, an indirect jump whose cleared target has bit 1 set raises excValid with excAddr equal to that cleared target. With compressedEn at 1 the same jump is taken.
- R9: linkVal always equals pc plus instLen. linkWe is 1 only for an indirect jump that raises no exception and names a nonzero rdIdx.
- R10: An indirect jump with rdIdx 0 keeps linkWe at 0.
- R11: With narrowMode at 1, comparisons use bits 31:0 of each operand, sign-extended. targetPc, linkVal and excAddr are sign-extended from bit 31.
- R12: taken and excValid are never 1 together, and excAddr is 0 whenever excValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs1Val | input | XLEN | First register operand |
| rs2Val | input | XLEN | Second register operand |
| pcIn | input | XLEN | Address of the current instruction |
| immVal | input | XLEN | Sign-extended immediate offset |
| instLen | input | 3 | Length of the current instruction in bytes (2 or 4) |
| xferOp | input | 3 | Operation code (see R1) |
| rdIdx | input | 5 | Destination register index for the link |
| narrowMode | input | 1 | 1 selects 32-bit operation |
| compressedEn | input | 1 | 1 when 16-bit instructions are enabled |
| taken | output | 1 | Transfer redirects to targetPc |
| targetPc | output | XLEN | Next program counter |
| linkVal | output | XLEN | Return address for the link register |
| linkWe | output | 1 | Link write enable |
| excValid | output | 1 | Misaligned-target exception |
| excAddr | output | XLEN | Faulting target address |

## Verification
Two things can fall on the same operation: the condition decision and the alignment check. A branch whose condition holds and whose target is misaligned must produce the exception rather than a redirect. A failing branch with the same target must produce neither. The bench provokes these cases deliberately by pairing the same odd-by-two target with conditions that hold and conditions that fail, under both settings of compressedEn. Random operands are also biased toward equal and sign-boundary values. Each outcome is judged against a bench model, and on every vector the bench also checks that taken and excValid are never 1 together.

// File: rtl/brj_pkg.sv
package brj_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_EQ   = 3'd1,
    OP_NE   = 3'd2,
    OP_LT   = 3'd3,
    OP_GE   = 3'd4,
    OP_LTU  = 3'd5,
    OP_GEU  = 3'd6,
    OP_JREG = 3'd7
  } xferOp_t;

  typedef struct packed {
    logic eq;
    logic ltS;
    logic ltU;
  } cmpFlags_t;

  typedef struct packed {
    logic selJump;
    logic redirect;
    logic raiseMis;
    logic linkWe;
  } xferStrobe_t;
endpackage

// File: rtl/brj_datapath.sv
module brj_datapath
  import brj_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] rs1Val,
  input  logic [XLEN-1:0] rs2Val,
  input  logic [XLEN-1:0] pcIn,
  input  logic [XLEN-1:0] immVal,
  input  logic [2:0]      instLen,
  input  logic            narrowMode,
  input  xferStrobe_t     strb,
  output cmpFlags_t       flags,
  output logic [1:0]      brLow,
  output logic            jrBit1,
  output logic [XLEN-1:0] targetPc,
  output logic [XLEN-1:0] linkVal,
  output logic [XLEN-1:0] excAddr
);
  localparam int NUM_FIT = 5;
  localparam int FIT_A = 0;
  localparam int FIT_B = 1;
  localparam int FIT_BR = 2;
  localparam int FIT_JR = 3;
  localparam int FIT_NX = 4;

  logic [XLEN-1:0] rawV [NUM_FIT];
  logic [XLEN-1:0] fitV [NUM_FIT];
  logic [XLEN-1:0] sumJr;

  assign sumJr = rs1Val + immVal;
  assign rawV[FIT_A]  = rs1Val;
  assign rawV[FIT_B]  = rs2Val;
  assign rawV[FIT_BR] = pcIn + immVal;
  assign rawV[FIT_JR] = {sumJr[XLEN-1:1], 1'b0};
  assign rawV[FIT_NX] = pcIn + XLEN'(instLen);

  for (genvar i = 0; i < NUM_FIT; i++) begin : gFit
    if (XLEN > 32) begin : gWide
      assign fitV[i] = narrowMode ? {{(XLEN-32){rawV[i][31]}}, rawV[i][31:0]} : rawV[i];
    end else begin : gNarrow
      assign fitV[i] = rawV[i];
    end
  end

  always_comb begin
    flags.eq  = (fitV[FIT_A] == fitV[FIT_B]);
    flags.ltS = ($signed(fitV[FIT_A]) < $signed(fitV[FIT_B]));
    flags.ltU = (fitV[FIT_A] < fitV[FIT_B]);
  end

  logic [XLEN-1:0] chosenTgt;
  assign chosenTgt = strb.selJump ? fitV[FIT_JR] : fitV[FIT_BR];
  assign brLow    = fitV[FIT_BR][1:0];
  assign jrBit1   = fitV[FIT_JR][1];
  assign targetPc = strb.redirect ? chosenTgt : fitV[FIT_NX];
  assign excAddr  = strb.raiseMis ? chosenTgt : '0;
  assign linkVal  = fitV[FIT_NX];
endmodule

// File: rtl/brj_control.sv
module brj_control
  import brj_pkg::*;
(
  input  xferOp_t     op,
  input  cmpFlags_t   flags,
  input  logic [1:0]  brLow,
  input  logic        jrBit1,
  input  logic        compressedEn,
  input  logic [4:0]  rdIdx,
  output xferStrobe_t strb
);
  logic condMet;
  logic isBranch;
  logic isJump;
  logic misAl;

  always_comb begin
    condMet  = 1'b0;
    isBranch = 1'b1;
    isJump   = 1'b0;
    unique case (op)
      OP_EQ:   condMet = flags.eq;
      OP_NE:   condMet = !flags.eq;
      OP_LT:   condMet = flags.ltS;
      OP_GE:   condMet = !flags.ltS;
      OP_LTU:  condMet = flags.ltU;
      OP_GEU:  condMet = !flags.ltU;
      OP_JREG: begin
        isBranch = 1'b0;
        isJump   = 1'b1;
        condMet  = 1'b1;
      end
      default: isBranch = 1'b0;
    endcase
  end

  always_comb begin
    misAl = 1'b0;
    if (!compressedEn) begin
      if (isJump)        misAl = jrBit1;
      else if (isBranch) misAl = |brLow;
    end
  end

  always_comb begin
    strb.selJump  = isJump;
    strb.raiseMis = condMet && misAl;
    strb.redirect = condMet && !misAl;
    strb.linkWe   = isJump && !misAl && (rdIdx != 5'd0);
  end
endmodule

// File: rtl/brj_resolver.sv
module brj_resolver
  import brj_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] rs1Val,
  input  logic [XLEN-1:0] rs2Val,
  input  logic [XLEN-1:0] pcIn,
  input  logic [XLEN-1:0] immVal,
  input  logic [2:0]      instLen,
  input  logic [2:0]      xferOp,
  input  logic [4:0]      rdIdx,
  input  logic            narrowMode,
  input  logic            compressedEn,
  output logic            taken,
  output logic [XLEN-1:0] targetPc,
  output logic [XLEN-1:0] linkVal,
  output logic            linkWe,
  output logic            excValid,
  output logic [XLEN-1:0] excAddr
);
  xferStrobe_t strb;
  cmpFlags_t   flags;
  logic [1:0]  brLow;
  logic        jrBit1;

  brj_control u_ctl (
    .op(xferOp_t'(xferOp)), .flags(flags), .brLow(brLow), .jrBit1(jrBit1),
    .compressedEn(compressedEn), .rdIdx(rdIdx), .strb(strb)
  );

  brj_datapath #(.XLEN(XLEN)) u_dp (
    .rs1Val(rs1Val), .rs2Val(rs2Val), .pcIn(pcIn), .immVal(immVal),
    .instLen(instLen), .narrowMode(narrowMode), .strb(strb), .flags(flags),
    .brLow(brLow), .jrBit1(jrBit1), .targetPc(targetPc), .linkVal(linkVal),
    .excAddr(excAddr)
  );

  assign taken    = strb.redirect;
  assign excValid = strb.raiseMis;
  assign linkWe   = strb.linkWe;
endmodule

// File: rtl/brj_resolver_chk.sv
module brj_resolver_chk #(
  parameter int XLEN = 64
) (
  input logic [2:0]      xferOp,
  input logic [4:0]      rdIdx,
  input logic            compressedEn,
  input logic            taken,
  input logic [XLEN-1:0] targetPc,
  input logic [XLEN-1:0] linkVal,
  input logic            linkWe,
  input logic            excValid,
  input logic [XLEN-1:0] excAddr
);
  always_comb begin
    // R12
    taken_exc_excl_chk: assert (!(taken && excValid));
    // R12
    exc_addr_quiet_chk: assert (excValid || excAddr == '0);
    // R10
    link_x0_chk: assert (!(linkWe && rdIdx == 5'd0));
    // R9
    link_jump_only_chk: assert (!linkWe || (xferOp == 3'd7 && taken));
    // R5
    mis_needs_nocomp_chk: assert (!excValid || !compressedEn);
    // R7
    jump_even_chk: assert (!(taken && xferOp == 3'd7) || !targetPc[0]);
    // R4
    fallthru_chk: assert (taken || targetPc == linkVal);
    // R1
    idle_quiet_chk: assert (xferOp != 3'd0 || (!taken && !excValid && !linkWe));
  end
endmodule

bind brj_resolver brj_resolver_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/brj_resolver_test.sv
module brj_resolver_test;
  localparam int XLEN = 64;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [XLEN-1:0] rs1Val, rs2Val, pcIn, immVal;
  logic [2:0] instLen, xferOp;
  logic [4:0] rdIdx;
  logic narrowMode, compressedEn;
  logic taken, linkWe, excValid;
  logic [XLEN-1:0] targetPc, linkVal, excAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  brj_resolver #(.XLEN(XLEN)) uut (
    .rs1Val(rs1Val), .rs2Val(rs2Val), .pcIn(pcIn), .immVal(immVal),
    .instLen(instLen), .xferOp(xferOp), .rdIdx(rdIdx), .narrowMode(narrowMode),
    .compressedEn(compressedEn), .taken(taken), .targetPc(targetPc),
    .linkVal(linkVal), .linkWe(linkWe), .excValid(excValid), .excAddr(excAddr)
  );

  function automatic logic [XLEN-1:0] fit(input logic [XLEN-1:0] v, input logic n);
    return n ? {{(XLEN-32){v[31]}}, v[31:0]} : v;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                       input logic [XLEN-1:0] pc, input logic [XLEN-1:0] imm, input logic [2:0] len,
                       input logic [4:0] rd, input logic nrw, input logic cen, input string tag);
    logic [XLEN-1:0] oa, ob, nxt, bt, jt, eTgt, eExcA;
    logic cond, mis, eTaken, eExc, eWe;
    @(posedge clk);
    xferOp = op; rs1Val = a; rs2Val = b; pcIn = pc; immVal = imm;
    instLen = len; rdIdx = rd; narrowMode = nrw; compressedEn = cen;
    oa = fit(a, nrw); ob = fit(b, nrw);
    nxt = fit(pc + XLEN'(len), nrw);
    bt = fit(pc + imm, nrw);
    jt = fit((a + imm) & ~XLEN'(1), nrw);
    cond = 0; mis = 0;
    case (op)
      3'd1: cond = (oa == ob);
      3'd2: cond = (oa != ob);
      3'd3: cond = ($signed(oa) < $signed(ob));
      3'd4: cond = ($signed(oa) >= $signed(ob));
      3'd5: cond = (oa < ob);
      3'd6: cond = (oa >= ob);
      3'd7: cond = 1;
      default: cond = 0;
    endcase
    if (op == 3'd7) mis = !cen && jt[1];
    else if (op != 3'd0) mis = !cen && (bt[1:0] != 2'b00);
    eTaken = cond && !mis;
    eExc = cond && mis;
    eTgt = eTaken ? ((op == 3'd7) ? jt : bt) : nxt;
    eExcA = eExc ? ((op == 3'd7) ? jt : bt) : '0;
    eWe = (op == 3'd7) && !mis && (rd != 0);
    @(negedge clk);
    chk(taken === eTaken, tag, "taken", XLEN'(taken), XLEN'(eTaken));
    chk(excValid === eExc, tag, "excValid", XLEN'(excValid), XLEN'(eExc));
    chk(targetPc === eTgt, tag, "targetPc", targetPc, eTgt);
    chk(excAddr === eExcA, tag, "excAddr", excAddr, eExcA);
    chk(linkVal === nxt, "R9", "linkVal", linkVal, nxt);
    chk(linkWe === eWe, tag, "linkWe", XLEN'(linkWe), XLEN'(eWe));
    chk(!(taken && excValid), "R12", "exclusive", XLEN'({taken, excValid}), '0);
  endtask

  function automatic logic [XLEN-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(WATCHDOG * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    xferOp = 3'd0; rs1Val = '0; rs2Val = '0; pcIn = 64'h1000; immVal = '0;
    instLen = 3'd4; rdIdx = 5'd0; narrowMode = 0; compressedEn = 0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset/idle state
    chk(!taken && !excValid && !linkWe, "R1", "idle outputs",
        XLEN'({taken, excValid, linkWe}), '0);
    chk(targetPc == 64'h1004, "R1", "idle target", targetPc, 64'h1004);

    apply(3'd0, 64'd5, 64'd5, 64'h2000, 64'h40, 3'd4, 5'd3, 0, 0, "R1");
    // R2 signed versus unsigned on the same operands
    apply(3'd3, '1, 64'd1, 64'h2000, 64'h40, 3'd4, 5'd0, 0, 0, "R2");
    apply(3'd5, '1, 64'd1, 64'h2000, 64'h40, 3'd4, 5'd0, 0, 0, "R2");
    apply(3'd4, 64'd7, 64'd7, 64'h2000, 64'h40, 3'd4, 5'd0, 0, 0, "R2");
    apply(3'd6, 64'd0, '1, 64'h2000, 64'h40, 3'd4, 5'd0, 0, 0, "R2");
    apply(3'd2, 64'd7, 64'd7, 64'h2000, 64'h40, 3'd4, 5'd0, 0, 0, "R2");
    // R3 taken branch, negative offset
    apply(3'd1, 64'd9, 64'd9, 64'h2000, -64'sd16, 3'd4, 5'd0, 0, 0, "R3");
    // same misaligned target: fails (R4) / holds (R5) / compressed (R6)
    apply(3'd1, 64'd1, 64'd2, 64'h2000, 64'h2, 3'd4, 5'd0, 0, 0, "R4");
    apply(3'd1, 64'd2, 64'd2, 64'h2000, 64'h2, 3'd4, 5'd0, 0, 0, "R5");
    apply(3'd2, 64'd1, 64'd2, 64'h2000, 64'h6, 3'd2, 5'd0, 0, 0, "R5");
    apply(3'd1, 64'd2, 64'd2, 64'h2000, 64'h2, 3'd2, 5'd0, 0, 1, "R6");
    // R7 bit 0 cleared
    apply(3'd7, 64'h3001, '0, 64'h2000, 64'h4, 3'd4, 5'd1, 0, 0, "R7");
    // R8 bit 1 after clearing
    apply(3'd7, 64'h3003, '0, 64'h2000, 64'h0, 3'd4, 5'd1, 0, 0, "R8");
    apply(3'd7, 64'h3003, '0, 64'h2000, 64'h0, 3'd4, 5'd1, 0, 1, "R8");
    // R9 link with 2-byte instruction
    apply(3'd7, 64'h4000, '0, 64'h2002, 64'h8, 3'd2, 5'd31, 0, 1, "R9");
    // R10 x0 link suppressed
    apply(3'd7, 64'h4000, '0, 64'h2000, 64'h8, 3'd4, 5'd0, 0, 0, "R10");
    // R11 narrow compare and sign extension
    apply(3'd3, 64'h0000_0000_8000_0000, '0, 64'h2000, 64'h8, 3'd4, 5'd0, 1, 0, "R11");
    apply(3'd3, 64'h0000_0000_8000_0000, '0, 64'h2000, 64'h8, 3'd4, 5'd0, 0, 0, "R11");
    apply(3'd1, 64'hdead_0000_1234_5678, 64'h0000_0000_1234_5678, 64'h7fff_fff0, 64'h20,
          3'd4, 5'd0, 1, 0, "R11");
    apply(3'd7, 64'h7fff_fffc, '0, 64'h10, 64'h8, 3'd4, 5'd2, 1, 0, "R11");

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op;
      logic [XLEN-1:0] a, b, imm, pc;
      op = 3'($urandom_range(0, 7));
      a = rnd64();
      b = ($urandom_range(0, 3) == 0) ? a : rnd64();
      if ($urandom_range(0, 4) == 0) b = {a[XLEN-1:32], ~a[31], a[30:0]};
      imm = {{51{$urandom_range(0, 1) == 1}}, 13'($urandom)};
      imm[0] = 1'b0;
      pc = rnd64(); pc[0] = 1'b0;
      apply(op, a, b, pc, imm, ($urandom_range(0, 1) == 1) ? 3'd4 : 3'd2,
            5'($urandom), 1'($urandom), 1'($urandom),
            (op == 3'd0) ? "R1" : (op == 3'd7) ? "R7" : "R2");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule